// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block is a watchdog timer that runs on the oscillator clock. It guards against software that stops making progress. A 3-bit rate field selects one of seven timeout periods, each a power of two, or turns the watchdog off. A window flag limits servicing to the final quarter of the period. To restart the count, software writes two key bytes in a fixed order to a service register.

When the period runs out without a valid service, the block raises a single-cycle timeout strobe toward the reset sequencer. It raises the same strobe for a wrong key byte, and for a service completed before the window opens. The reset sequencer turns that strobe into a system reset.

The control register can be written only once after reset, unless the test-mode input is high. Every accepted control write restarts the count.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset `timeout` is low and the rate is 0, which means the watchdog is off. While the rate is 0 the counter is held at zero, no timeout occurs, and service writes are ignored.
- R2: With rate n (1..7) and no service, `timeout` goes high exactly 2^(BASE_EXP+2n) cycles after the clock edge that restarted the count. It stays high for exactly one cycle and then repeats with the same period.
- R3: A control write (`wrSel`=0) carries the rate in data bits [2:0] and the window flag in data bit 7. An accepted control write restarts the count and discards any half-entered key.
- R4: Outside test mode, only the first control write after reset is accepted. Later control writes have no effect on rate, window flag or count.
- R5: While `testMode` is high, every control write is accepted, including one that writes rate 0 to turn the watchdog off.
- R6: Only reset clears the write-once lock.
- R7: A service write (`wrSel`=1) of 0x55 followed by a service write of 0xAA restarts the count without a timeout.
- R8: A service byte that is not the expected next key raises a timeout and restarts the count. Examples are 0xAA without a preceding 0x55, 0x55 twice in a row, or any byte other than 0x55 and 0xAA. The key progress is cleared.
- R9: With the window flag set, the completing 0xAA is valid only when the count has reached at least three quarters of the period. An earlier 0xAA is a failure as in R8. With the flag clear, a service is valid at any count.
- R10: A valid service completed in the last cycle of the period takes precedence over expiry, so no timeout is raised.
- R11: The timeout for a failing write appears in the cycle after the edge that samples the write. The count reads zero whenever `timeout` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | High lifts the write-once lock on the control register |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control register, 1 selects the service register |
| wrData | input | 8 | Write data |
| timeout | output | 1 | One-cycle strobe: watchdog failure |

## Verification
The bench builds the block with BASE_EXP=2, which shrinks the periods to 16 cycles for rate 1 and 256 cycles for rate 3. At that size, exact period counts, the lock, and test-mode rewrites can be measured cycle by cycle. In the 16-cycle period the window opens at count 12, so the bench can place a service just before the window, just inside it, and on the very last cycle of the period with simple gap values.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int RATE_W    = 3;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int MAX_RATE  = NUM_RATES - 1;
  localparam int WIN_BIT   = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {
    KEY_IDLE,
    KEY_ARMED
  } keyState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;
    logic fail;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [7:0]        wrData,
  input  logic              inWindow,
  input  logic              expire,
  output wdgStrobe_t        strobe,
  output logic [RATE_W-1:0] rateSel,
  output logic              windowEn,
  output logic              locked
);
  keyState_t keyState, keyNext;
  logic ctrlAccept, svcWrite;
  logic restartC, failC;

  assign ctrlAccept = wrEn && !wrSel && (!locked || testMode);
  assign svcWrite   = wrEn && wrSel && (rateSel != '0);

  always_comb begin
    restartC = 1'b0;
    failC    = 1'b0;
    keyNext  = keyState;
    if (ctrlAccept) begin
      restartC = 1'b1;
      keyNext  = KEY_IDLE;
    end else if (svcWrite) begin
      case (keyState)
        KEY_IDLE: begin
          if (wrData == KEY_FIRST) keyNext = KEY_ARMED;
          else                     failC   = 1'b1;
        end
        KEY_ARMED: begin
          keyNext = KEY_IDLE;
          if (wrData == KEY_SECOND && (!windowEn || inWindow)) restartC = 1'b1;
          else                                                 failC    = 1'b1;
        end
        default: keyNext = KEY_IDLE;
      endcase
    end
    if (expire && !restartC && !failC) keyNext = KEY_IDLE;
  end

  assign strobe.restart = restartC;
  assign strobe.fail    = failC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel  <= '0;
      windowEn <= 1'b0;
      locked   <= 1'b0;
      keyState <= KEY_IDLE;
    end else begin
      keyState <= keyNext;
      if (ctrlAccept) begin
        rateSel  <= wrData[RATE_W-1:0];
        windowEn <= wrData[WIN_BIT];
        locked   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 12,
  localparam int CNT_W   = BASE_EXP + 2 * MAX_RATE
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  wdgStrobe_t        strobe,
  output logic              expire,
  output logic              inWindow,
  output logic              timeout,
  output logic [CNT_W-1:0]  countVal
);
  logic [CNT_W-1:0] lastTab [NUM_RATES];
  logic [CNT_W-1:0] winTab  [NUM_RATES];
  logic enabled;

  // divider taps: one terminal count and one window start per rate
  for (genvar g = 0; g < NUM_RATES; g++) begin : gTap
    if (g == 0) begin : gOff
      assign lastTab[g] = '0;
      assign winTab[g]  = '0;
    end else begin : gOn
      localparam longint unsigned SPAN = 64'd1 << (BASE_EXP + 2 * g);
      assign lastTab[g] = CNT_W'(SPAN - 64'd1);
      assign winTab[g]  = CNT_W'(SPAN - (SPAN >> 2));
    end
  end

  assign enabled  = (rateSel != '0);
  assign expire   = enabled && (countVal == lastTab[rateSel]);
  assign inWindow = (countVal >= winTab[rateSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      timeout  <= 1'b0;
    end else begin
      timeout <= strobe.fail || (expire && !strobe.restart);
      if (!enabled || strobe.restart || strobe.fail || expire)
        countVal <= '0;
      else
        countVal <= countVal + CNT_W'(1);
    end
  end
endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 12
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       testMode,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic       timeout
);
  localparam int CNT_W = BASE_EXP + 2 * MAX_RATE;

  wdgStrobe_t        strobe;
  logic [RATE_W-1:0] rateSel;
  logic              windowEn;
  logic              ctrlLocked;
  logic              expire;
  logic              inWindow;
  logic [CNT_W-1:0]  countVal;

  wdg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .testMode(testMode),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .inWindow(inWindow), .expire(expire),
    .strobe(strobe), .rateSel(rateSel), .windowEn(windowEn), .locked(ctrlLocked)
  );

  wdg_count #(.BASE_EXP(BASE_EXP)) uCount (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .strobe(strobe),
    .expire(expire), .inWindow(inWindow), .timeout(timeout), .countVal(countVal)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int BASE_EXP = 12,
  localparam int CNT_W   = BASE_EXP + 14
)(
  input logic             clk,
  input logic             rstN,
  input logic             testMode,
  input logic             wrEn,
  input logic             wrSel,
  input logic [7:0]       wrData,
  input logic             timeout,
  input logic [2:0]       rate,
  input logic             locked,
  input logic [CNT_W-1:0] cnt
);
  // R1
  off_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rate) == 3'd0) |-> !timeout);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rate != 3'd0) |-> (64'(cnt) < (64'd1 << (BASE_EXP + 2 * int'(rate)))));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !testMode && wrEn && !wrSel) |=> $stable(rate));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R8
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && rate != 3'd0 && wrData != 8'h55 && wrData != 8'hAA) |=> timeout);

  // R11
  strobe_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (cnt == '0));
endmodule

bind keyed_window_watchdog wdg_checker #(.BASE_EXP(BASE_EXP)) uChk (
  .clk(clk), .rstN(rstN), .testMode(testMode), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .timeout(timeout), .rate(rateSel), .locked(ctrlLocked),
  .cnt(countVal)
);

// File: tb/keyed_window_watchdog_test.sv
`timescale 1ns/1ps
module keyed_window_watchdog_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic timeout;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  keyed_window_watchdog #(.BASE_EXP(2)) uut (
    .clk(clk), .rstN(rstN), .testMode(testMode), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .timeout(timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected under 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // at a negedge: drive for one cycle, return at next negedge
  task automatic wr(input logic sel, input logic [7:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // cycles until timeout seen high, 0 if none within limit
  task automatic measure(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (timeout) begin n = k; return; end
    end
  endtask

  // {ctrl, gap, byte0, byte1, expTimeout0, expTimeout1}; rate 1 => 16-cycle period, window from count 12
  localparam logic [33:0] VEC [10] = '{
    {8'h01, 8'd0,  8'h55, 8'hAA, 1'b0, 1'b0},  // R7 normal service
    {8'h01, 8'd0,  8'hAA, 8'h55, 1'b1, 1'b0},  // R8 second key first
    {8'h01, 8'd0,  8'h12, 8'h55, 1'b1, 1'b0},  // R8 stray byte
    {8'h01, 8'd0,  8'h55, 8'h55, 1'b0, 1'b1},  // R8 repeated first key
    {8'h01, 8'd0,  8'h55, 8'h12, 1'b0, 1'b1},  // R8 bad second byte
    {8'h81, 8'd11, 8'h55, 8'hAA, 1'b0, 1'b0},  // R9 window just open
    {8'h81, 8'd10, 8'h55, 8'hAA, 1'b0, 1'b1},  // R9 one cycle early
    {8'h81, 8'd14, 8'h55, 8'hAA, 1'b0, 1'b0},  // R10 last cycle
    {8'h81, 8'd0,  8'h55, 8'hAA, 1'b0, 1'b1},  // R9 far too early
    {8'h00, 8'd0,  8'hAA, 8'h12, 1'b0, 1'b0}   // R1 disabled ignores keys
  };

  initial begin
    int n;
    @(negedge clk);
    doReset();

    // R1 reset state and off behaviour
    check(timeout == 1'b0, "R1 reset timeout", int'(timeout), 0);
    wr(1'b1, 8'h12);
    check(timeout == 1'b0, "R1 service ignored when off", int'(timeout), 0);
    measure(100, n);
    check(n == 0, "R1 no timeout when off", n, 0);

    // R2 and R3 period with rate 1, one-cycle strobe, repeat
    wr(1'b0, 8'h01);
    measure(40, n);
    check(n == 16, "R2 first period", n, 16);
    @(negedge clk);
    check(timeout == 1'b0, "R2 strobe one cycle", int'(timeout), 0);
    measure(40, n);
    check(n == 15, "R2 repeat period", n, 15);

    // R4 locked write ignored (would have disabled)
    wr(1'b0, 8'h00);
    measure(40, n);
    check(n == 15, "R4 locked write no effect", n, 15);

    // R6 reset clears lock; rate 3 -> 256
    doReset();
    wr(1'b0, 8'h03);
    measure(400, n);
    check(n == 256, "R6 write after reset accepted, R2 rate 3", n, 256);

    // R5 test mode rewrite restarts, and can disable
    doReset();
    testMode = 1'b1;
    wr(1'b0, 8'h01);
    repeat (9) @(negedge clk);
    wr(1'b0, 8'h01);
    measure(40, n);
    check(n == 16, "R5 test-mode rewrite restart", n, 16);
    wr(1'b0, 8'h00);
    measure(60, n);
    check(n == 0, "R5 test-mode disable", n, 0);

    // R7 service restarts count
    wr(1'b0, 8'h01);
    repeat (3) @(negedge clk);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    measure(40, n);
    check(n == 16, "R7 service restarts count", n, 16);

    // R8 and R11 bad key: strobe next cycle, count restarted
    wr(1'b0, 8'h01);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h33);
    check(timeout == 1'b1, "R11 fail strobe next cycle", int'(timeout), 1);
    measure(40, n);
    check(n == 16, "R8 fail restarts count", n, 16);

    // vector table, test mode allows each control rewrite
    for (int i = 0; i < 10; i++) begin
      wr(1'b0, VEC[i][33:26]);
      repeat (int'(VEC[i][25:18])) @(negedge clk);
      wr(1'b1, VEC[i][17:10]);
      check(timeout == VEC[i][1], $sformatf("vec %0d byte0 R7 R8 R9 R10 R1", i),
            int'(timeout), int'(VEC[i][1]));
      wr(1'b1, VEC[i][9:2]);
      check(timeout == VEC[i][0], $sformatf("vec %0d byte1 R7 R8 R9 R10 R1", i),
            int'(timeout), int'(VEC[i][0]));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule